// File: doc/BRIEF.md
# Multi-Level Interrupt Priority Controller

This block gathers interrupt activity from a set of lines into one pending register and masks it with an enable register. Each line is assigned a priority level and a trigger type, both fixed at elaboration. A line can be typed as level or edge. A level-typed pending bit follows its line down again. An edge-typed bit stays latched until software clears it. The pending register ANDed with the enable register forms the effective request vector. An arbiter then searches that vector for the highest configured level that is strictly above the processor's current interrupt level. It reports that level number and a request flag to the core.

Line activity arrives as single-cycle events. Each event carries a line number and the new state of the line. An event can also carry an external interrupt number, which a fixed table translates to an internal line. Events that name a line beyond the implemented count are dropped. External numbers with no table entry, or whose entry points past the implemented lines, are dropped as well. Software can load the enable register, set pending bits, and clear latched edge bits by writing ones to them. It also supplies the current interrupt level.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset, the pending register, the enable register, `pendLevel` and `irqReq` are all zero.
- R2: An internal event (`evtExt`=0) with `evtActive`=1 for a line below `NUM_INTS` sets that line's bit on `pendOut`. The bit is visible one clock edge after the event cycle.
- R3: An event with `evtActive`=0 clears the pending bit of a level-typed line, where bit i of `EDGE_LINES` is 0. An edge-typed line, where bit i is 1, keeps its bit set.
- R4: A write with `clrWe` clears the pending bits where `clrData` is 1, but only on edge-typed lines; level-typed bits are unaffected. When a set and a clear hit the same bit in one cycle, the bit ends up set.
- R5: `enWe` loads `enData` into the enable register, and `setWe` ORs `setData` into the pending register. Bits at or above `NUM_INTS` always read as zero on both `pendOut` and `enableOut`.
- R6: A pending line whose enable bit is 0 contributes nothing to arbitration.
- R7: `pendLevel` is the highest level L, with 1 ≤ L ≤ `NUM_LEVELS` and L > `curLevel`, such that some line whose `LINE_LEVEL` equals L is both pending and enabled. `irqReq` is 1 whenever such a level exists. Lines with a level of 0 or above `NUM_LEVELS` never raise a request.
- R8: If no level qualifies, `pendLevel` is 0 and `irqReq` is 0.
- R9: An internal event whose index is at or above `NUM_INTS` changes nothing.
- R10: An external event (`evtExt`=1) with number e < `NUM_EXT` acts on line `EXT_MAP[e]`. An external number at or above `NUM_EXT`, or one that maps to a line at or above `NUM_INTS`, changes nothing.
- R11: `pendLevel` and `irqReq` are registered. At each clock edge they take the result computed from the pending register, the enable register and `curLevel` as they stood in the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | A line-activity event is presented this cycle |
| evtExt | input | 1 | 1: `evtIdx` is an external number; 0: an internal line index |
| evtIdx | input | IDX_W | Line index or external number of the event |
| evtActive | input | 1 | New state of the line: 1 active, 0 inactive |
| enWe | input | 1 | Load the enable register from `enData` |
| enData | input | NUM_LINES | Enable register write data |
| setWe | input | 1 | OR `setData` into the pending register |
| setData | input | NUM_LINES | Pending set data |
| clrWe | input | 1 | Write-one-to-clear on edge-typed pending bits |
| clrData | input | NUM_LINES | Pending clear data |
| curLevel | input | LVL_W | Processor's current interrupt level |
| pendOut | output | NUM_LINES | Pending register contents |
| enableOut | output | NUM_LINES | Enable register contents |
| pendLevel | output | LVL_W | Highest qualifying level, 0 if none |
| irqReq | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with 16 lines, of which 12 are implemented, 4 priority levels and a 4-entry external table. It also gives one implemented line level 0 and another level 5, so the two "never requests" cases of R7 can be driven directly. One external table entry points at line 13, past the implemented count, which makes the dropped-translation path of R10 reachable. Indices 12 to 15 fit in the event index field, so R9 can be exercised on lines that exist in the field width but are not implemented. Edge and level lines are mixed within several levels, so clear rules and arbitration are tested together.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  // Width of the decoded line number carried in the strobe struct.
  localparam int LINE_W = 8;

  typedef struct packed {
    logic              hwSet;   // event marks a line active
    logic              hwClr;   // event drops a level-typed line
    logic [LINE_W-1:0] line;    // decoded internal line number
    logic              enLoad;  // load enable register
    logic              swSet;   // software set of pending bits
    logic              swClr;   // software clear of edge bits
  } irqStrobes_t;

endpackage

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_level_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int NUM_INTS  = 32,
  parameter int NUM_EXT   = 8,
  parameter int IDX_W     = 5,
  parameter logic [NUM_LINES-1:0] EDGE_LINES = '0,
  parameter int EXT_MAP [NUM_EXT] = '{default: 0}
) (
  input  logic             evtValid,
  input  logic             evtExt,
  input  logic [IDX_W-1:0] evtIdx,
  input  logic             evtActive,
  input  logic             enWe,
  input  logic             setWe,
  input  logic             clrWe,
  output irqStrobes_t      strobes
);

  int   lineNum;
  logic inRange;
  logic isEdge;

  // Translate the event into an internal line number and range flag.
  always_comb begin
    lineNum = int'(evtIdx);
    inRange = 1'b1;
    if (evtExt) begin
      lineNum = 0;
      inRange = 1'b0;
      for (int e = 0; e < NUM_EXT; e++) begin
        if (int'(evtIdx) == e) begin
          lineNum = EXT_MAP[e];
          inRange = 1'b1;
        end
      end
    end
    if (lineNum < 0 || lineNum >= NUM_INTS) begin
      inRange = 1'b0;
    end
  end

  always_comb begin
    isEdge = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (i == lineNum) isEdge = EDGE_LINES[i];
    end
  end

  always_comb begin
    strobes.hwSet  = evtValid && inRange && evtActive;
    strobes.hwClr  = evtValid && inRange && !evtActive && !isEdge;
    strobes.line   = inRange ? LINE_W'(lineNum) : '0;
    strobes.enLoad = enWe;
    strobes.swSet  = setWe;
    strobes.swClr  = clrWe;
  end

endmodule

// File: rtl/irq_level_dp.sv
module irq_level_dp
  import irq_level_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int NUM_INTS   = 32,
  parameter int NUM_LEVELS = 7,
  parameter int LVL_W      = 3,
  parameter logic [NUM_LINES-1:0] EDGE_LINES = '0,
  parameter int LINE_LEVEL [NUM_LINES] = '{default: 1}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  irqStrobes_t          strobes,
  input  logic [NUM_LINES-1:0] enData,
  input  logic [NUM_LINES-1:0] setData,
  input  logic [NUM_LINES-1:0] clrData,
  input  logic [LVL_W-1:0]     curLevel,
  output logic [NUM_LINES-1:0] pendReg,
  output logic [NUM_LINES-1:0] enReg,
  output logic [LVL_W-1:0]     pendLevel,
  output logic                 irqReq
);

  function automatic logic [NUM_LINES-1:0] implMask();
    logic [NUM_LINES-1:0] m;
    for (int i = 0; i < NUM_LINES; i++) m[i] = (i < NUM_INTS);
    return m;
  endfunction

  function automatic logic [NUM_LINES-1:0] maskForLevel(int lvl);
    logic [NUM_LINES-1:0] m;
    for (int i = 0; i < NUM_LINES; i++) m[i] = (LINE_LEVEL[i] == lvl) && (i < NUM_INTS);
    return m;
  endfunction

  localparam logic [NUM_LINES-1:0] IMPL_MASK = implMask();

  logic [NUM_LINES-1:0] hwBit;
  logic [NUM_LINES-1:0] setBits;
  logic [NUM_LINES-1:0] clrBits;
  logic [NUM_LINES-1:0] pendNext;
  logic [NUM_LINES-1:0] effVec;
  logic [NUM_LEVELS:0][NUM_LINES-1:0] levelMask;
  logic [LVL_W-1:0]     winLevel;

  // One-hot of the decoded event line.
  for (genvar i = 0; i < NUM_LINES; i++) begin : gHwBit
    assign hwBit[i] = (int'(strobes.line) == i);
  end

  // Per-level line masks derived from the per-line level table.
  for (genvar g = 0; g <= NUM_LEVELS; g++) begin : gLevelMask
    assign levelMask[g] = maskForLevel(g);
  end

  // Clear first, then set: a set in the same cycle wins.
  always_comb begin
    setBits  = (strobes.hwSet ? hwBit : '0) | (strobes.swSet ? setData : '0);
    clrBits  = (strobes.hwClr ? hwBit : '0) | (strobes.swClr ? (clrData & EDGE_LINES) : '0);
    pendNext = ((pendReg & ~clrBits) | setBits) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      enReg   <= '0;
    end else begin
      pendReg <= pendNext;
      if (strobes.enLoad) enReg <= enData & IMPL_MASK;
    end
  end

  assign effVec = pendReg & enReg;

  // Walk levels upward; the last qualifying one is the highest.
  always_comb begin
    winLevel = '0;
    for (int lv = 1; lv <= NUM_LEVELS; lv++) begin
      if (lv > int'(curLevel) && (levelMask[lv] & effVec) != '0) begin
        winLevel = LVL_W'(lv);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendLevel <= '0;
      irqReq    <= 1'b0;
    end else begin
      pendLevel <= winLevel;
      irqReq    <= (winLevel != '0);
    end
  end

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_level_pkg::*;
#(
  parameter int NUM_LINES  = 32,
  parameter int NUM_INTS   = 32,
  parameter int NUM_LEVELS = 7,
  parameter int LVL_W      = 3,
  parameter int NUM_EXT    = 8,
  parameter logic [NUM_LINES-1:0] EDGE_LINES = '0,
  parameter int LINE_LEVEL [NUM_LINES] = '{default: 1},
  parameter int EXT_MAP [NUM_EXT] = '{default: 0},
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtValid,
  input  logic                 evtExt,
  input  logic [IDX_W-1:0]     evtIdx,
  input  logic                 evtActive,
  input  logic                 enWe,
  input  logic [NUM_LINES-1:0] enData,
  input  logic                 setWe,
  input  logic [NUM_LINES-1:0] setData,
  input  logic                 clrWe,
  input  logic [NUM_LINES-1:0] clrData,
  input  logic [LVL_W-1:0]     curLevel,
  output logic [NUM_LINES-1:0] pendOut,
  output logic [NUM_LINES-1:0] enableOut,
  output logic [LVL_W-1:0]     pendLevel,
  output logic                 irqReq
);

  irqStrobes_t strobes;

  irq_event_ctrl #(
    .NUM_LINES (NUM_LINES),
    .NUM_INTS  (NUM_INTS),
    .NUM_EXT   (NUM_EXT),
    .IDX_W     (IDX_W),
    .EDGE_LINES(EDGE_LINES),
    .EXT_MAP   (EXT_MAP)
  ) u_ctrl (
    .evtValid (evtValid),
    .evtExt   (evtExt),
    .evtIdx   (evtIdx),
    .evtActive(evtActive),
    .enWe     (enWe),
    .setWe    (setWe),
    .clrWe    (clrWe),
    .strobes  (strobes)
  );

  irq_level_dp #(
    .NUM_LINES (NUM_LINES),
    .NUM_INTS  (NUM_INTS),
    .NUM_LEVELS(NUM_LEVELS),
    .LVL_W     (LVL_W),
    .EDGE_LINES(EDGE_LINES),
    .LINE_LEVEL(LINE_LEVEL)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .enData   (enData),
    .setData  (setData),
    .clrData  (clrData),
    .curLevel (curLevel),
    .pendReg  (pendOut),
    .enReg    (enableOut),
    .pendLevel(pendLevel),
    .irqReq   (irqReq)
  );

endmodule

// File: rtl/irq_level_arbiter_chk.sv
module irq_level_arbiter_chk #(
  parameter int NUM_LINES = 32,
  parameter int NUM_INTS  = 32,
  parameter int LVL_W     = 3,
  parameter int IDX_W     = 5,
  parameter logic [NUM_LINES-1:0] EDGE_LINES = '0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 evtValid,
  input logic                 evtExt,
  input logic [IDX_W-1:0]     evtIdx,
  input logic                 evtActive,
  input logic                 setWe,
  input logic                 clrWe,
  input logic [LVL_W-1:0]     curLevel,
  input logic [NUM_LINES-1:0] pendOut,
  input logic [NUM_LINES-1:0] enableOut,
  input logic [LVL_W-1:0]     pendLevel,
  input logic                 irqReq
);

  // R2
  evt_sets_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtExt && evtActive && int'(evtIdx) < NUM_INTS) |=> pendOut[$past(evtIdx)]);

  // R3
  level_line_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtExt && !evtActive && int'(evtIdx) < NUM_INTS
     && !EDGE_LINES[evtIdx] && !setWe) |=> !pendOut[$past(evtIdx)]);

  // R4
  edge_bit_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrWe |=> (($past(pendOut) & EDGE_LINES & ~pendOut) == '0));

  // R5
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendOut >> NUM_INTS) == '0) && ((enableOut >> NUM_INTS) == '0));

  // R7
  level_above_current_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (pendLevel > $past(curLevel)));

  // R8
  no_effective_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendOut & enableOut) == '0) |=> (!irqReq && pendLevel == '0));

  // R11
  level_holds_when_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(pendOut) && $stable(enableOut) && $stable(curLevel)) |=> $stable(pendLevel));

endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_INTS  (NUM_INTS),
  .LVL_W     (LVL_W),
  .IDX_W     (IDX_W),
  .EDGE_LINES(EDGE_LINES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtValid (evtValid),
  .evtExt   (evtExt),
  .evtIdx   (evtIdx),
  .evtActive(evtActive),
  .setWe    (setWe),
  .clrWe    (clrWe),
  .curLevel (curLevel),
  .pendOut  (pendOut),
  .enableOut(enableOut),
  .pendLevel(pendLevel),
  .irqReq   (irqReq)
);

// File: tb/irq_level_arbiter_bench.sv
module irq_level_arbiter_bench;

  localparam int NL = 16;
  localparam int NI = 12;
  localparam int NV = 4;
  localparam int LW = 3;
  localparam int NE = 4;
  localparam int IW = 4;
  // Edge-typed lines: 1, 3, 5, 7, 11.
  localparam logic [NL-1:0] EDGES = 16'h08AA;
  localparam int LVLS [NL] = '{1, 1, 2, 2, 3, 3, 4, 4, 0, 5, 1, 2, 4, 4, 4, 4};
  localparam int XMAP [NE] = '{6, 2, 13, 10};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evtValid = 1'b0;
  logic          evtExt = 1'b0;
  logic [IW-1:0] evtIdx = '0;
  logic          evtActive = 1'b0;
  logic          enWe = 1'b0;
  logic [NL-1:0] enData = '0;
  logic          setWe = 1'b0;
  logic [NL-1:0] setData = '0;
  logic          clrWe = 1'b0;
  logic [NL-1:0] clrData = '0;
  logic [LW-1:0] curLevel = '0;
  logic [NL-1:0] pendOut;
  logic [NL-1:0] enableOut;
  logic [LW-1:0] pendLevel;
  logic          irqReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_level_arbiter #(
    .NUM_LINES(NL), .NUM_INTS(NI), .NUM_LEVELS(NV), .LVL_W(LW), .NUM_EXT(NE),
    .EDGE_LINES(EDGES), .LINE_LEVEL(LVLS), .EXT_MAP(XMAP)
  ) u_irq_level_arbiter (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtExt(evtExt), .evtIdx(evtIdx),
    .evtActive(evtActive), .enWe(enWe), .enData(enData), .setWe(setWe),
    .setData(setData), .clrWe(clrWe), .clrData(clrData), .curLevel(curLevel),
    .pendOut(pendOut), .enableOut(enableOut), .pendLevel(pendLevel), .irqReq(irqReq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkLevel(string req, int lvl);
    check({req, " level"}, 32'(pendLevel), 32'(lvl));
    check({req, " request"}, 32'(irqReq), (lvl != 0) ? 32'd1 : 32'd0);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic evt(bit ext, int idx, bit act);
    evtValid = 1'b1; evtExt = ext; evtIdx = IW'(idx); evtActive = act;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic wrEn(logic [NL-1:0] d);
    enWe = 1'b1; enData = d;
    @(negedge clk);
    enWe = 1'b0;
  endtask

  task automatic wrSet(logic [NL-1:0] d);
    setWe = 1'b1; setData = d;
    @(negedge clk);
    setWe = 1'b0;
  endtask

  task automatic wrClr(logic [NL-1:0] d);
    clrWe = 1'b1; clrData = d;
    @(negedge clk);
    clrWe = 1'b0;
  endtask

  task automatic testReset();
    check("R1 pending", 32'(pendOut), 0);
    check("R1 enable", 32'(enableOut), 0);
    checkLevel("R1", 0);
  endtask

  task automatic testEnable();
    wrEn(16'hFFFF);
    check("R5 enable upper bits dropped", 32'(enableOut), 32'h0FFF);
    settle();
  endtask

  task automatic testFirstRequest();
    evt(1'b0, 0, 1'b1);
    check("R2 line0 set", 32'(pendOut), 32'h0001);
    check("R11 request not yet", 32'(irqReq), 0);
    settle();
    checkLevel("R7 line0", 1);
    evt(1'b0, 4, 1'b1);
    check("R2 line4 set", 32'(pendOut), 32'h0011);
    settle();
    checkLevel("R7 highest wins", 3);
  endtask

  task automatic testThreshold();
    curLevel = 3'd3;
    settle();
    checkLevel("R8 all at or below current", 0);
    curLevel = 3'd2;
    settle();
    checkLevel("R7 above current", 3);
    curLevel = 3'd0;
    settle();
  endtask

  task automatic testClearRules();
    evt(1'b0, 4, 1'b0);
    check("R3 level line clears", 32'(pendOut), 32'h0001);
    settle();
    checkLevel("R3 after clear", 1);
    evt(1'b0, 7, 1'b1);
    evt(1'b0, 7, 1'b0);
    check("R3 edge line latched", 32'(pendOut), 32'h0081);
    settle();
    checkLevel("R7 edge line level", 4);
    wrClr(16'h0081);
    check("R4 w1c edge only", 32'(pendOut), 32'h0001);
    settle();
    checkLevel("R4 after w1c", 1);
  endtask

  task automatic testDisable();
    wrEn(16'h0000);
    settle();
    check("R6 pending kept", 32'(pendOut), 32'h0001);
    checkLevel("R6 disabled", 0);
    wrEn(16'hFFFF);
    settle();
    checkLevel("R6 re-enabled", 1);
  endtask

  task automatic testOddLevels();
    evt(1'b0, 0, 1'b0);
    evt(1'b0, 8, 1'b1);
    evt(1'b0, 9, 1'b1);
    check("R7 odd-level lines pending", 32'(pendOut), 32'h0300);
    settle();
    checkLevel("R7 level 0 and 5 lines", 0);
    evt(1'b0, 8, 1'b0);
    evt(1'b0, 9, 1'b0);
    check("R3 odd lines cleared", 32'(pendOut), 32'h0000);
  endtask

  task automatic testOutOfRange();
    evt(1'b0, 12, 1'b1);
    evt(1'b0, 15, 1'b1);
    settle();
    check("R9 indices ignored", 32'(pendOut), 32'h0000);
    checkLevel("R9 no request", 0);
  endtask

  task automatic testExternal();
    evt(1'b1, 0, 1'b1);
    check("R10 ext0 to line6", 32'(pendOut), 32'h0040);
    settle();
    checkLevel("R10 ext0 level", 4);
    evt(1'b1, 2, 1'b1);
    evt(1'b1, 5, 1'b1);
    check("R10 bad ext ignored", 32'(pendOut), 32'h0040);
    evt(1'b1, 0, 1'b0);
    check("R10 ext0 inactive clears", 32'(pendOut), 32'h0000);
    evt(1'b1, 3, 1'b1);
    check("R10 ext3 to line10", 32'(pendOut), 32'h0400);
    settle();
    checkLevel("R10 ext3 level", 1);
  endtask

  task automatic testSoftware();
    wrSet(16'hF002);
    check("R5 sw set", 32'(pendOut), 32'h0402);
    wrClr(16'h0400);
    check("R4 w1c on level line ignored", 32'(pendOut), 32'h0402);
    settle();
    checkLevel("R5 after sw set", 1);
    evtValid = 1'b1; evtExt = 1'b0; evtIdx = IW'(3); evtActive = 1'b1;
    clrWe = 1'b1; clrData = 16'h0008;
    @(negedge clk);
    evtValid = 1'b0; clrWe = 1'b0;
    check("R4 set beats clear", 32'(pendOut), 32'h040A);
    settle();
    checkLevel("R7 line3 level", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnable();
    testFirstRequest();
    testThreshold();
    testClearRules();
    testDisable();
    testOddLevels();
    testOutOfRange();
    testExternal();
    testSoftware();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule